// File: doc/BRIEF.md
# Parallel Programming Target Interface

This block is the device-side controller of a byte-wide parallel programming port on a small microcontroller. An external programmer drives a strobe whose rising edge latches one byte from the data bus. A two-bit action code picks whether that byte is an address byte, a data byte or a command. A two-bit byte-select code picks which byte of the address, of the data word or of the fuse set is meant. The byte-select meaning depends on the operation.

Flash data is staged word by word into a page buffer with a separate page-load strobe. A falling edge of the active-low write strobe then commits the buffer to the addressed page. EEPROM works the same way, with byte-wide entries. Fuse and lock bytes are written directly by the write strobe. While a commit is in progress, a ready flag is low and further writes are refused. Reads are combinational from the latched address, the current byte-select pins and the loaded command. The data bus is driven only while the active-low output enable is asserted.

Storage is register-based and behavioural. A signature space holds three identification bytes and a calibration byte. The calibration byte is presented on an oscillator-trim output from reset onwards. All strobes are sampled on the block clock and are assumed to be synchronous to it.

Top module: `ppt_target`

## Requirements
- R1: On a rising edge of `stb_i` (seen at the next clock edge), `act_i` selects the action: 00 loads an address byte, 01 loads a data byte, 10 loads the command byte, and 11 changes nothing.
- R2: For address loading, `bsel_i` 00, 01 and 10 write address bits [7:0], [15:8] and [23:16]. Code 11 leaves the address unchanged.
- R3: For data loading, `bsel_i` 00 writes the low data byte and 01 the high data byte. Codes 10 and 11 change nothing. Under the flash-read command, `bsel_i` 00 returns the low byte, 01 the high byte, and 10 or 11 return 0xFF.
- R4: Under the fuse-write command, a write pulse with `bsel_i` 00, 01 or 10 stores the low data byte into the low, high or extended fuse. Code 11 stores nothing. Under the configuration-read command, `bsel_i` 00 returns the fuse low byte, 01 the lock byte, 10 the extended fuse and 11 the fuse high byte.
- R5: An accepted write pulse (a falling edge of `wr_ni` while ready, under a write command) drops `ready_o` for exactly BUSY_CYC clock cycles, starting with the cycle after the edge.
- R6: `data_oe_o` is 1 only while `oe_ni` is 0. `data_o` is 0x00 whenever `data_oe_o` is 0.
- R7: Under the flash page-write command (0x10), a `pload_i` rising edge stores {high data byte, low data byte} into the flash page buffer at word index address[6:0]. An accepted write copies the whole buffer into the page selected by address[16:7], and only the low FLASH_PG_BITS bits of that field are decoded.
- R8: Under the EEPROM page-write command (0x11), a `pload_i` rising edge stores the low data byte into the EEPROM buffer at address[2:0]. An accepted write copies the buffer into the page selected by address[11:3], and only the low EE_PG_BITS bits of that field are decoded. The EEPROM read returns the byte for `bsel_i` 00 and 0xFF otherwise.
- R9: While `ready_o` is 0, write pulses and page-load pulses are ignored. Flash, EEPROM, fuse and lock contents stay unchanged, and the busy period is not extended.
- R10: Lock bit 0 at 0 makes flash and EEPROM reads return 0xFF. Under the signature-read command (0x08) with `bsel_i` 00, address[7:0] values 0, 1 and 2 return SIG0, SIG1 and SIG2 (defaults 0xA5, 0x3C, 0x07) whatever the lock byte holds. Other locations return 0xFF.
- R11: The signature read with `bsel_i` 01 at location 0 returns CAL_VAL (default 0x6B). `osc_cal_o` equals CAL_VAL from reset onwards.
- R12: After reset, `ready_o` is 1, `data_oe_o` is 0, and the lock byte is 0xFF. The fuses read FUSE_LO_RST, FUSE_HI_RST and FUSE_EXT_RST (defaults 0x62, 0x99, 0xFF). Flash words read 0xFFFF and EEPROM bytes read 0xFF.
- R13: The command codes are: 0x10 flash page write, 0x11 EEPROM page write, 0x20 lock write (low data byte, any `bsel_i`), 0x40 fuse write, 0x02 flash read, 0x03 EEPROM read, 0x04 configuration read and 0x08 signature read. Any other code reads as 0xFF and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | Latch strobe; rising edge performs the action chosen by act_i |
| act_i | input | 2 | Action select: address, data, command or none |
| bsel_i | input | 2 | Byte select; meaning depends on the operation |
| wr_ni | input | 1 | Active-low write strobe; falling edge executes the write command |
| oe_ni | input | 1 | Active-low output enable for reads |
| pload_i | input | 1 | Page-load strobe; rising edge fills the page buffer |
| data_i | input | 8 | Data bus input from the pad |
| data_o | output | 8 | Data bus output towards the pad |
| data_oe_o | output | 1 | Pad driver enable for data_o |
| ready_o | output | 1 | 1 when a new write may be accepted, 0 while committing |
| osc_cal_o | output | 8 | Oscillator calibration value loaded at reset |

## Verification
A wrong latched address, data or command byte only shows up at the ports on the next read under output enable. The bench therefore reads back after every store, and a mis-decoded byte select shows as a wrong byte in that same read. A faulty busy counter shows at once as a wrong count of low `ready_o` cycles. A missing busy gate lets a refused write reach storage, and this shows in the first read after ready returns. Page-buffer index errors show only after the commit, as words that land at the wrong offset or neighbours that lose their erased 0xFFFF value.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  typedef enum logic [1:0] {
    ACT_ADDR = 2'b00,
    ACT_DATA = 2'b01,
    ACT_CMD  = 2'b10,
    ACT_NONE = 2'b11
  } act_e;

  localparam logic [7:0] CMD_WR_FLASH = 8'h10;
  localparam logic [7:0] CMD_WR_EE    = 8'h11;
  localparam logic [7:0] CMD_WR_LOCK  = 8'h20;
  localparam logic [7:0] CMD_WR_FUSE  = 8'h40;
  localparam logic [7:0] CMD_RD_FLASH = 8'h02;
  localparam logic [7:0] CMD_RD_EE    = 8'h03;
  localparam logic [7:0] CMD_RD_CFG   = 8'h04;
  localparam logic [7:0] CMD_RD_SIG   = 8'h08;
endpackage

// File: rtl/ppt_edge.sv
module ppt_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= ~RISE;
    else         prev_q <= in_i;

  generate
    if (RISE) begin : g_rise
      assign pulse_o = in_i & ~prev_q;
    end else begin : g_fall
      assign pulse_o = ~in_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/ppt_latch.sv
module ppt_latch
  import ppt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stb_i,
  input  logic [1:0]  act_i,
  input  logic [1:0]  bsel_i,
  input  logic [7:0]  data_i,
  output logic [23:0] addr_o,
  output logic [7:0]  dlo_o,
  output logic [7:0]  dhi_o,
  output logic [7:0]  cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_o <= '0;
      dlo_o  <= 8'hFF;
      dhi_o  <= 8'hFF;
      cmd_o  <= 8'h00;
    end else if (stb_i) begin
      case (act_i)
        ACT_ADDR: begin
          case (bsel_i)
            2'b00:   addr_o[7:0]   <= data_i;
            2'b01:   addr_o[15:8]  <= data_i;
            2'b10:   addr_o[23:16] <= data_i;
            default: ;
          endcase
        end
        ACT_DATA: begin
          case (bsel_i)
            2'b00:   dlo_o <= data_i;
            2'b01:   dhi_o <= data_i;
            default: ;
          endcase
        end
        ACT_CMD: cmd_o <= data_i;
        default: ;
      endcase
    end
endmodule

// File: rtl/ppt_nvm.sv
module ppt_nvm #(
  parameter int WB  = 7,
  parameter int FPB = 2,
  parameter int EB  = 3,
  parameter int EPB = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pl_flash_i,
  input  logic               pl_ee_i,
  input  logic               cm_flash_i,
  input  logic               cm_ee_i,
  input  logic [WB+FPB-1:0]  faddr_i,
  input  logic [EB+EPB-1:0]  eaddr_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        frd_o,
  output logic [7:0]         erd_o
);
  localparam int FW = 1 << WB;
  localparam int FP = 1 << FPB;
  localparam int EW = 1 << EB;
  localparam int EP = 1 << EPB;

  logic [WB-1:0]  fword;
  logic [FPB-1:0] fpage;
  logic [EB-1:0]  eidx;
  logic [EPB-1:0] epage;
  assign fword = faddr_i[WB-1:0];
  assign fpage = faddr_i[WB +: FPB];
  assign eidx  = eaddr_i[EB-1:0];
  assign epage = eaddr_i[EB +: EPB];

  logic [15:0] fbuf_q [FW];
  logic [7:0]  ebuf_q [EW];
  logic [15:0] fpg_rd [FP];
  logic [7:0]  epg_rd [EP];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int w = 0; w < FW; w++) fbuf_q[w] <= 16'hFFFF;
    end else if (pl_flash_i) begin
      fbuf_q[fword] <= wdata_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int b = 0; b < EW; b++) ebuf_q[b] <= 8'hFF;
    end else if (pl_ee_i) begin
      ebuf_q[eidx] <= wdata_i[7:0];
    end

  for (genvar p = 0; p < FP; p++) begin : g_fpg
    logic [15:0] mem_q [FW];
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        for (int w = 0; w < FW; w++) mem_q[w] <= 16'hFFFF;
      end else if (cm_flash_i && fpage == FPB'(p)) begin
        for (int w = 0; w < FW; w++) mem_q[w] <= fbuf_q[w];
      end
    assign fpg_rd[p] = mem_q[fword];
  end

  for (genvar p = 0; p < EP; p++) begin : g_epg
    logic [7:0] mem_q [EW];
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        for (int b = 0; b < EW; b++) mem_q[b] <= 8'hFF;
      end else if (cm_ee_i && epage == EPB'(p)) begin
        for (int b = 0; b < EW; b++) mem_q[b] <= ebuf_q[b];
      end
    assign epg_rd[p] = mem_q[eidx];
  end

  assign frd_o = fpg_rd[fpage];
  assign erd_o = epg_rd[epage];
endmodule

// File: rtl/ppt_cfg.sv
module ppt_cfg #(
  parameter logic [7:0] FUSE_LO_RST  = 8'h62,
  parameter logic [7:0] FUSE_HI_RST  = 8'h99,
  parameter logic [7:0] FUSE_EXT_RST = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_fuse_i,
  input  logic       wr_lock_i,
  input  logic [1:0] bsel_i,
  input  logic [7:0] d_i,
  output logic [7:0] fuse_lo_o,
  output logic [7:0] fuse_hi_o,
  output logic [7:0] fuse_ext_o,
  output logic [7:0] lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      fuse_lo_o  <= FUSE_LO_RST;
      fuse_hi_o  <= FUSE_HI_RST;
      fuse_ext_o <= FUSE_EXT_RST;
    end else if (wr_fuse_i) begin
      case (bsel_i)
        2'b00:   fuse_lo_o  <= d_i;
        2'b01:   fuse_hi_o  <= d_i;
        2'b10:   fuse_ext_o <= d_i;
        default: ;
      endcase
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        lock_o <= 8'hFF;
    else if (wr_lock_i) lock_o <= d_i;
endmodule

// File: rtl/ppt_target.sv
module ppt_target
  import ppt_pkg::*;
#(
  parameter int         PG_WORD_BITS  = 7,
  parameter int         FLASH_PG_BITS = 2,
  parameter int         EE_BYTE_BITS  = 3,
  parameter int         EE_PG_BITS    = 3,
  parameter int         BUSY_CYC      = 16,
  parameter logic [7:0] SIG0          = 8'hA5,
  parameter logic [7:0] SIG1          = 8'h3C,
  parameter logic [7:0] SIG2          = 8'h07,
  parameter logic [7:0] CAL_VAL       = 8'h6B,
  parameter logic [7:0] FUSE_LO_RST   = 8'h62,
  parameter logic [7:0] FUSE_HI_RST   = 8'h99,
  parameter logic [7:0] FUSE_EXT_RST  = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic [1:0] act_i,
  input  logic [1:0] bsel_i,
  input  logic       wr_ni,
  input  logic       oe_ni,
  input  logic       pload_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic       ready_o,
  output logic [7:0] osc_cal_o
);
  localparam int CW  = $clog2(BUSY_CYC + 1);
  localparam int FAW = PG_WORD_BITS + FLASH_PG_BITS;
  localparam int EAW = EE_BYTE_BITS + EE_PG_BITS;
  localparam int AU  = (FAW > EAW) ? ((FAW > 8) ? FAW : 8) : ((EAW > 8) ? EAW : 8);

  logic        stb_p, pload_p, wr_p;
  logic [23:0] addr_q;
  logic [7:0]  dlo_q, dhi_q, cmd_q;
  logic [7:0]  fuse_lo, fuse_hi, fuse_ext, lock_q;
  logic [15:0] flash_word;
  logic [7:0]  ee_byte;
  logic [CW-1:0] busy_q;
  logic        wr_go, pl_go, is_wr;
  logic [7:0]  rd_byte;
  logic [7:0]  cal_q;
  logic        unused_addr;

  assign unused_addr = ^addr_q[23:AU];

  ppt_edge #(.RISE(1'b1)) i_stb_edge (.clk_i, .rst_ni, .in_i(stb_i),   .pulse_o(stb_p));
  ppt_edge #(.RISE(1'b1)) i_pl_edge  (.clk_i, .rst_ni, .in_i(pload_i), .pulse_o(pload_p));
  ppt_edge #(.RISE(1'b0)) i_wr_edge  (.clk_i, .rst_ni, .in_i(wr_ni),   .pulse_o(wr_p));

  ppt_latch i_latch (
    .clk_i, .rst_ni, .stb_i(stb_p), .act_i, .bsel_i, .data_i,
    .addr_o(addr_q), .dlo_o(dlo_q), .dhi_o(dhi_q), .cmd_o(cmd_q)
  );

  assign is_wr = (cmd_q == CMD_WR_FLASH) || (cmd_q == CMD_WR_EE) ||
                 (cmd_q == CMD_WR_FUSE)  || (cmd_q == CMD_WR_LOCK);
  assign ready_o = (busy_q == '0);
  assign wr_go   = wr_p & ready_o & is_wr;
  assign pl_go   = pload_p & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         busy_q <= '0;
    else if (wr_go)      busy_q <= CW'(BUSY_CYC);
    else if (!ready_o)   busy_q <= busy_q - 1'b1;

  ppt_nvm #(
    .WB(PG_WORD_BITS), .FPB(FLASH_PG_BITS), .EB(EE_BYTE_BITS), .EPB(EE_PG_BITS)
  ) i_nvm (
    .clk_i, .rst_ni,
    .pl_flash_i(pl_go && cmd_q == CMD_WR_FLASH),
    .pl_ee_i   (pl_go && cmd_q == CMD_WR_EE),
    .cm_flash_i(wr_go && cmd_q == CMD_WR_FLASH),
    .cm_ee_i   (wr_go && cmd_q == CMD_WR_EE),
    .faddr_i(addr_q[FAW-1:0]), .eaddr_i(addr_q[EAW-1:0]),
    .wdata_i({dhi_q, dlo_q}),
    .frd_o(flash_word), .erd_o(ee_byte)
  );

  ppt_cfg #(
    .FUSE_LO_RST(FUSE_LO_RST), .FUSE_HI_RST(FUSE_HI_RST), .FUSE_EXT_RST(FUSE_EXT_RST)
  ) i_cfg (
    .clk_i, .rst_ni,
    .wr_fuse_i(wr_go && cmd_q == CMD_WR_FUSE),
    .wr_lock_i(wr_go && cmd_q == CMD_WR_LOCK),
    .bsel_i, .d_i(dlo_q),
    .fuse_lo_o(fuse_lo), .fuse_hi_o(fuse_hi), .fuse_ext_o(fuse_ext), .lock_o(lock_q)
  );

  // calibration copy happens only at reset
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cal_q <= CAL_VAL;
    else         cal_q <= cal_q;
  assign osc_cal_o = cal_q;

  always_comb begin
    rd_byte = 8'hFF;
    case (cmd_q)
      CMD_RD_FLASH: if (lock_q[0]) begin
        case (bsel_i)
          2'b00:   rd_byte = flash_word[7:0];
          2'b01:   rd_byte = flash_word[15:8];
          default: rd_byte = 8'hFF;
        endcase
      end
      CMD_RD_EE: if (lock_q[0] && bsel_i == 2'b00) rd_byte = ee_byte;
      CMD_RD_CFG: begin
        case (bsel_i)
          2'b00:   rd_byte = fuse_lo;
          2'b01:   rd_byte = lock_q;
          2'b10:   rd_byte = fuse_ext;
          default: rd_byte = fuse_hi;
        endcase
      end
      CMD_RD_SIG: begin
        if (bsel_i == 2'b00) begin
          case (addr_q[7:0])
            8'd0:    rd_byte = SIG0;
            8'd1:    rd_byte = SIG1;
            8'd2:    rd_byte = SIG2;
            default: rd_byte = 8'hFF;
          endcase
        end else if (bsel_i == 2'b01 && addr_q[7:0] == 8'd0) begin
          rd_byte = CAL_VAL;
        end
      end
      default: rd_byte = 8'hFF;
    endcase
  end

  assign data_oe_o = ~oe_ni;
  assign data_o    = data_oe_o ? rd_byte : 8'h00;
endmodule

// File: rtl/ppt_target_chk.sv
module ppt_target_chk #(
  parameter int BUSY_CYC = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        oe_ni,
  input logic        data_oe_o,
  input logic        ready_o,
  input logic        wr_go,
  input logic        stb_p,
  input logic [1:0]  act_i,
  input logic [1:0]  bsel_i,
  input logic [23:0] addr_q,
  input logic [7:0]  fuse_lo,
  input logic [7:0]  fuse_hi,
  input logic [7:0]  fuse_ext,
  input logic [7:0]  lock_q
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          low_cnt <= '0;
    else if (ready_o)                     low_cnt <= '0;
    else if (low_cnt <= (CW+1)'(BUSY_CYC)) low_cnt <= low_cnt + 1'b1;

  AST_OE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o); // R6
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(wr_go)); // R5
  AST_BUSY_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= (CW+1)'(BUSY_CYC)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ready_o) |-> $stable({fuse_lo, fuse_hi, fuse_ext, lock_q})); // R9
  AST_ADDR_RESV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_p && act_i == 2'b00 && bsel_i == 2'b11) |=> $stable(addr_q)); // R2
  AST_ACT_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_p && act_i == 2'b11) |=> $stable(addr_q)); // R1
endmodule

bind ppt_target ppt_target_chk #(.BUSY_CYC(BUSY_CYC)) i_ppt_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_ni(oe_ni), .data_oe_o(data_oe_o),
  .ready_o(ready_o), .wr_go(wr_go), .stb_p(stb_p), .act_i(act_i), .bsel_i(bsel_i),
  .addr_q(addr_q), .fuse_lo(fuse_lo), .fuse_hi(fuse_hi), .fuse_ext(fuse_ext),
  .lock_q(lock_q)
);

// File: tb/test_ppt_target.sv
`timescale 1ns/1ps
module test_ppt_target;
  import ppt_pkg::*;

  localparam int         BUSY = 16;
  localparam logic [7:0] SIG0 = 8'hA5, SIG1 = 8'h3C, SIG2 = 8'h07, CAL = 8'h6B;
  localparam logic [7:0] FLO  = 8'h62, FHI  = 8'h99, FEX  = 8'hFF;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       stb = 1'b0, wr_n = 1'b1, oe_n = 1'b1, pload = 1'b0;
  logic [1:0] act = 2'b11, bsel = 2'b00;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, osc_cal;
  logic       doe, ready;

  int n_chk = 0, n_fail = 0;

  ppt_target i_ppt_target (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .act_i(act), .bsel_i(bsel),
    .wr_ni(wr_n), .oe_ni(oe_n), .pload_i(pload), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .ready_o(ready), .osc_cal_o(osc_cal)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic lat(input logic [1:0] a, input logic [1:0] b, input logic [7:0] v);
    @(negedge clk); act = a; bsel = b; din = v; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic set_addr(input logic [23:0] a);
    lat(2'b00, 2'b00, a[7:0]);
    lat(2'b00, 2'b01, a[15:8]);
    lat(2'b00, 2'b10, a[23:16]);
  endtask

  task automatic set_cmd(input logic [7:0] c);
    lat(2'b10, 2'b00, c);
  endtask

  task automatic pl_pulse();
    @(negedge clk); pload = 1'b1;
    @(negedge clk); pload = 1'b0;
  endtask

  task automatic wr_pulse(input logic [1:0] b);
    @(negedge clk); bsel = b; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input logic [1:0] b, output logic [7:0] v);
    @(negedge clk); bsel = b; oe_n = 1'b0;
    #1 v = dout;
    chk("R6 oe drives bus", doe, 1'b1);
    @(negedge clk); oe_n = 1'b1;
    #1 chk("R6 bus released", {doe, dout}, 9'h000);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R12 ready after reset", ready, 1'b1);
    chk("R12 oe after reset", doe, 1'b0);
    chk("R11 osc cal", osc_cal, CAL);
    set_cmd(CMD_RD_CFG);
    rd(2'b00, v); chk("R12 fuse lo reset", v, FLO);
    rd(2'b01, v); chk("R12 lock reset", v, 8'hFF);
    rd(2'b10, v); chk("R12 fuse ext reset", v, FEX);
    rd(2'b11, v); chk("R12 fuse hi reset", v, FHI);
    set_cmd(CMD_RD_FLASH); set_addr(24'h000003);
    rd(2'b01, v); chk("R12 flash erased", v, 8'hFF);
  endtask

  task automatic t_flash();
    logic [7:0] v; int n;
    logic [15:0] w5 = 16'h5A21, w0 = 16'h0F00, w127 = 16'hC3E7;
    set_cmd(CMD_WR_FLASH);
    set_addr(24'h000100);
    lat(2'b01, 2'b00, w0[7:0]); lat(2'b01, 2'b01, w0[15:8]); pl_pulse();
    set_addr(24'h000105);
    lat(2'b01, 2'b00, w5[7:0]); lat(2'b01, 2'b01, w5[15:8]);
    lat(2'b01, 2'b10, 8'h99); lat(2'b01, 2'b11, 8'h77); // R3 reserved data selects
    pl_pulse();
    set_addr(24'h00017F);
    lat(2'b01, 2'b00, w127[7:0]); lat(2'b01, 2'b01, w127[15:8]); pl_pulse();
    wr_pulse(2'b00);
    wait_ready(n); chk("R5 busy length", n, BUSY);
    set_cmd(CMD_RD_FLASH);
    set_addr(24'h000105);
    rd(2'b00, v); chk("R7 word5 low", v, w5[7:0]);
    rd(2'b01, v); chk("R3 word5 high", v, w5[15:8]);
    rd(2'b10, v); chk("R3 reserved read select", v, 8'hFF);
    set_addr(24'h000100); rd(2'b01, v); chk("R7 word0 high", v, w0[15:8]);
    set_addr(24'h00017F); rd(2'b00, v); chk("R7 word127 low", v, w127[7:0]);
    set_addr(24'h000101); rd(2'b00, v); chk("R7 unloaded word", v, 8'hFF);
    set_addr(24'h000005); rd(2'b00, v); chk("R7 other page untouched", v, 8'hFF);
    set_addr(24'h000905); rd(2'b00, v); chk("R7 page field aliasing", v, w5[7:0]);
  endtask

  task automatic t_busy();
    logic [7:0] v; int n;
    set_cmd(CMD_WR_FLASH);
    set_addr(24'h000105);
    wr_pulse(2'b00);
    lat(2'b01, 2'b00, 8'hEF); lat(2'b01, 2'b01, 8'hBE);
    pl_pulse(); wr_pulse(2'b00);
    wait_ready(n); chk("R9 busy not extended", n, BUSY - 8);
    set_cmd(CMD_RD_FLASH); rd(2'b00, v); chk("R9 flash kept", v, 8'h21);
    set_cmd(CMD_WR_FLASH); wr_pulse(2'b00);
    set_cmd(CMD_RD_FLASH); rd(2'b01, v); chk("R9 buffer kept", v, 8'h5A);
    wait_ready(n);
    set_cmd(CMD_WR_FLASH); wr_pulse(2'b00);
    set_cmd(CMD_WR_FUSE); lat(2'b01, 2'b00, 8'h00); wr_pulse(2'b00);
    wait_ready(n);
    set_cmd(CMD_RD_CFG); rd(2'b00, v); chk("R9 fuse kept", v, FLO);
  endtask

  task automatic t_ee();
    logic [7:0] v; int n;
    set_cmd(CMD_WR_EE);
    set_addr(24'h000018); lat(2'b01, 2'b00, 8'h3D); pl_pulse();
    set_addr(24'h00001F); lat(2'b01, 2'b00, 8'hD4); pl_pulse();
    wr_pulse(2'b00); wait_ready(n);
    set_cmd(CMD_RD_EE);
    set_addr(24'h000018); rd(2'b00, v); chk("R8 ee byte0", v, 8'h3D);
    rd(2'b01, v); chk("R8 ee high select", v, 8'hFF);
    set_addr(24'h00001F); rd(2'b00, v); chk("R8 ee byte7", v, 8'hD4);
    set_addr(24'h000019); rd(2'b00, v); chk("R8 ee unloaded", v, 8'hFF);
    set_addr(24'h000008); rd(2'b00, v); chk("R8 ee other page", v, 8'hFF);
  endtask

  task automatic t_fuse();
    logic [7:0] v; int n;
    set_cmd(CMD_WR_FUSE);
    lat(2'b01, 2'b00, 8'h11); wr_pulse(2'b00); wait_ready(n);
    lat(2'b01, 2'b00, 8'h22); wr_pulse(2'b01); wait_ready(n);
    lat(2'b01, 2'b00, 8'h33); wr_pulse(2'b10); wait_ready(n);
    lat(2'b01, 2'b00, 8'h44); wr_pulse(2'b11); wait_ready(n);
    set_cmd(CMD_RD_CFG);
    rd(2'b00, v); chk("R4 fuse lo", v, 8'h11);
    rd(2'b01, v); chk("R4 lock slot", v, 8'hFF);
    rd(2'b10, v); chk("R4 fuse ext", v, 8'h33);
    rd(2'b11, v); chk("R4 fuse hi", v, 8'h22);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    set_cmd(CMD_RD_SIG); set_addr(24'h000001);
    rd(2'b00, v); chk("R10 sig1", v, SIG1);
    lat(2'b11, 2'b00, 8'h02);
    rd(2'b00, v); chk("R1 action none", v, SIG1);
    lat(2'b00, 2'b11, 8'h02);
    rd(2'b00, v); chk("R2 reserved addr select", v, SIG1);
    lat(2'b00, 2'b01, 8'h01);
    rd(2'b00, v); chk("R2 high addr byte kept low", v, SIG1);
    set_cmd(8'h77); rd(2'b00, v); chk("R13 unknown cmd", v, 8'hFF);
  endtask

  task automatic t_lock();
    logic [7:0] v; int n;
    set_cmd(CMD_WR_LOCK); lat(2'b01, 2'b00, 8'hFE); wr_pulse(2'b10); wait_ready(n);
    set_cmd(CMD_RD_CFG); rd(2'b01, v); chk("R4 lock read", v, 8'hFE);
    set_cmd(CMD_RD_FLASH); set_addr(24'h000105);
    rd(2'b00, v); chk("R10 flash locked", v, 8'hFF);
    set_cmd(CMD_RD_EE); set_addr(24'h000018);
    rd(2'b00, v); chk("R10 ee locked", v, 8'hFF);
    set_cmd(CMD_RD_SIG);
    set_addr(24'h000000); rd(2'b00, v); chk("R10 sig0 locked", v, SIG0);
    rd(2'b01, v); chk("R11 cal byte", v, CAL);
    set_addr(24'h000002); rd(2'b00, v); chk("R10 sig2 locked", v, SIG2);
    set_addr(24'h000003); rd(2'b00, v); chk("R10 sig out of range", v, 8'hFF);
    chk("R11 osc cal held", osc_cal, CAL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flash();
    t_busy();
    t_ee();
    t_fuse();
    t_latch();
    t_lock();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule